// File: doc/BRIEF.md
# PHY Control-Register Handshake Sequencer

This block turns a single host request into the strobe-and-acknowledge sequence that a PHY's 16-bit control-register port expects. The PHY port uses level strobes: capture-address, capture-data, read and write. It also has one shared 16-bit input bus, a 16-bit output bus and an acknowledge line. Every step on that port is a full four-phase exchange: the strobe goes high, the acknowledge rises, the strobe goes low, and the acknowledge falls.

A read takes two such exchanges: first the address is latched, then the read is performed. A write takes three: the address is latched, then the data is latched, then the write is committed. The host presents a request with an address and write data. It watches `busy` while the work is in progress. A one-cycle `done` pulse marks the end, and for a read the returned word is then on `rd_data`.

The acknowledge from the PHY is synchronized before the sequencer uses it. A programmable limit caps each wait for the acknowledge. When a wait runs past that limit, the exchange is abandoned, a sticky error flag is set, and the sequencer returns to idle.

Top module: `phycr_seq`

## Requirements
- R1: A synchronous active-high reset drives all four strobes low, clears `phy_din` to 0, and clears `busy`, `done` and `err`.
- R2: A request is accepted only while the sequencer is idle. A request presented while busy has no effect on the handshakes, addresses or data sent to the PHY.
- R3: Every operation starts with an address exchange. The request address is placed on `phy_din`, and `phy_cap_addr` is raised while the address is held there.
- R4: Each exchange is four-phase. The strobe stays high until the synchronized acknowledge is high. The strobe is then dropped, and the next step waits until the acknowledge is low again. A strobe rises only while the acknowledge is low.
- R5: A write performs, in this order: address capture, data capture with the write data on `phy_din`, and write commit. That is three handshakes in total.
- R6: A read performs address capture and then a read handshake (two in total). `rd_data` takes the value of `phy_dout` while the acknowledge is high, before the read strobe falls.
- R7: Before any strobe rises, all four strobes have been low for at least one cycle. After a strobe falls, all strobes stay low for at least the next cycle.
- R8: At most one strobe is high at any time, and `phy_din` does not change while a strobe is high.
- R9: `busy` rises on the edge that accepts a request. It stays high until the final acknowledge-low is seen (or a timeout occurs), and it falls in the same cycle as a one-cycle `done` pulse. Strobes are all low whenever `busy` is low.
- R10: The sequencer waits for the acknowledge for at most `tmo_limit`+1 cycles per wait. When that wait expires, all strobes drop, `err` is set, `done` pulses and the sequencer returns to idle. If the PHY never raises the acknowledge, `done` appears `tmo_limit`+2 cycles after the accepting edge.
- R11: `err` stays set until reset. Later operations still complete normally while it is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken only when idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | PHY register address |
| req_wdata | input | 16 | Write data |
| tmo_limit | input | 8 | Acknowledge wait limit in cycles |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Sticky timeout flag |
| rd_data | output | 16 | Last read result |
| phy_din | output | 16 | Shared address/data bus to the PHY |
| phy_cap_addr | output | 1 | Capture-address strobe |
| phy_cap_data | output | 1 | Capture-data strobe |
| phy_rd | output | 1 | Read strobe |
| phy_wr | output | 1 | Write-commit strobe |
| phy_dout | input | 16 | Read data from the PHY |
| phy_ack | input | 1 | Handshake acknowledge from the PHY |

## Verification
The hardest case to reach from the ports is a timeout in the second half of a handshake. There, the PHY has raised its acknowledge and then never drops it. The bench's PHY model has a mode that holds the acknowledge high and another that fixes its reply delay at zero, so the expiry lands on an exactly predictable cycle. The same model has a mode that never answers at all, which tests the first-half timeout. To show that late sampling would be caught, the model drives a garbage value on its output bus once the read strobe falls.

// File: rtl/phycr_pkg.sv
package phycr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETUP,
        ST_WAIT_HI,
        ST_WAIT_LO
    } seq_state_t;

    typedef enum logic [1:0] {
        PH_ADDR,
        PH_DATA,
        PH_COMMIT,
        PH_READ
    } seq_phase_t;

    typedef struct packed {
        logic cap_addr;
        logic cap_data;
        logic rd;
        logic wr;
    } strobe_t;

    localparam strobe_t STB_NONE = '{cap_addr: 1'b0, cap_data: 1'b0, rd: 1'b0, wr: 1'b0};

    function automatic strobe_t phase_strobe(input seq_phase_t ph);
        strobe_t s;
        s = STB_NONE;
        case (ph)
            PH_ADDR:   s.cap_addr = 1'b1;
            PH_DATA:   s.cap_data = 1'b1;
            PH_COMMIT: s.wr       = 1'b1;
            PH_READ:   s.rd       = 1'b1;
            default:   s = STB_NONE;
        endcase
        return s;
    endfunction

    function automatic seq_phase_t phase_after(input seq_phase_t ph, input logic is_write);
        seq_phase_t n;
        case (ph)
            PH_ADDR: n = is_write ? PH_DATA : PH_READ;
            PH_DATA: n = PH_COMMIT;
            default: n = PH_ADDR;
        endcase
        return n;
    endfunction

    function automatic logic phase_is_last(input seq_phase_t ph);
        return (ph == PH_COMMIT) || (ph == PH_READ);
    endfunction

endpackage

// File: rtl/phycr_sync.sv
module phycr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= d;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/phycr_timer.sv
module phycr_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          run,
    input  logic [TW-1:0] limit,
    output logic          expired
);
    logic [TW-1:0] count;

    assign expired = run && (count == limit);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            count <= '0;
        end else if (run && !expired) begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/phycr_core.sv
module phycr_core
    import phycr_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [DW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic          ack_s,
    input  logic [DW-1:0] phy_dout,
    input  logic          tmr_expired,
    output logic          tmr_clear,
    output logic          tmr_run,
    output logic          busy,
    output logic          done,
    output logic          err,
    output logic [DW-1:0] rd_data,
    output logic [DW-1:0] phy_din,
    output strobe_t       stb
);
    seq_state_t    state;
    seq_phase_t    phase;
    logic          op_write;
    logic [DW-1:0] wdata_q;

    // The timer is cleared when a wait state is entered and runs only while waiting.
    assign tmr_run   = (state == ST_WAIT_HI) || (state == ST_WAIT_LO);
    assign tmr_clear = (state == ST_SETUP) || ((state == ST_WAIT_HI) && ack_s);

    assign busy = (state != ST_IDLE);
    assign stb  = (state == ST_WAIT_HI) ? phase_strobe(phase) : STB_NONE;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            phase    <= PH_ADDR;
            op_write <= 1'b0;
            wdata_q  <= '0;
            phy_din  <= '0;
            rd_data  <= '0;
            done     <= 1'b0;
            err      <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        op_write <= req_write;
                        wdata_q  <= req_wdata;
                        phy_din  <= req_addr;
                        phase    <= PH_ADDR;
                        state    <= ST_SETUP;
                    end
                end
                ST_SETUP: begin
                    state <= ST_WAIT_HI;
                end
                ST_WAIT_HI: begin
                    if (ack_s) begin
                        if (phase == PH_READ) begin
                            rd_data <= phy_dout;
                        end
                        state <= ST_WAIT_LO;
                    end else if (tmr_expired) begin
                        err   <= 1'b1;
                        done  <= 1'b1;
                        state <= ST_IDLE;
                    end
                end
                ST_WAIT_LO: begin
                    if (!ack_s) begin
                        if (phase_is_last(phase)) begin
                            done  <= 1'b1;
                            state <= ST_IDLE;
                        end else begin
                            phase <= phase_after(phase, op_write);
                            if (phase_after(phase, op_write) == PH_DATA) begin
                                phy_din <= wdata_q;
                            end
                            state <= ST_SETUP;
                        end
                    end else if (tmr_expired) begin
                        err   <= 1'b1;
                        done  <= 1'b1;
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/phycr_seq.sv
module phycr_seq
    import phycr_pkg::*;
#(
    parameter int DW        = 16,
    parameter int TW        = 8,
    parameter int SYNC_STGS = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [DW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic [TW-1:0] tmo_limit,
    output logic          busy,
    output logic          done,
    output logic          err,
    output logic [DW-1:0] rd_data,
    output logic [DW-1:0] phy_din,
    output logic          phy_cap_addr,
    output logic          phy_cap_data,
    output logic          phy_rd,
    output logic          phy_wr,
    input  logic [DW-1:0] phy_dout,
    input  logic          phy_ack
);
    logic    ack_s;
    logic    tmr_clear;
    logic    tmr_run;
    logic    tmr_expired;
    strobe_t stb;

    phycr_sync #(.STAGES(SYNC_STGS)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (phy_ack),
        .q   (ack_s)
    );

    phycr_timer #(.TW(TW)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .clear   (tmr_clear),
        .run     (tmr_run),
        .limit   (tmo_limit),
        .expired (tmr_expired)
    );

    phycr_core #(.DW(DW)) u_core (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .req_write   (req_write),
        .req_addr    (req_addr),
        .req_wdata   (req_wdata),
        .ack_s       (ack_s),
        .phy_dout    (phy_dout),
        .tmr_expired (tmr_expired),
        .tmr_clear   (tmr_clear),
        .tmr_run     (tmr_run),
        .busy        (busy),
        .done        (done),
        .err         (err),
        .rd_data     (rd_data),
        .phy_din     (phy_din),
        .stb         (stb)
    );

    assign phy_cap_addr = stb.cap_addr;
    assign phy_cap_data = stb.cap_data;
    assign phy_rd       = stb.rd;
    assign phy_wr       = stb.wr;
endmodule

// File: rtl/phycr_seq_chk.sv
module phycr_seq_chk #(
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          busy,
    input logic          done,
    input logic          err,
    input logic [DW-1:0] phy_din,
    input logic          phy_cap_addr,
    input logic          phy_cap_data,
    input logic          phy_rd,
    input logic          phy_wr,
    input logic          phy_ack
);
    logic [3:0] stbv;
    logic       any_stb;
    assign stbv    = {phy_cap_addr, phy_cap_data, phy_rd, phy_wr};
    assign any_stb = |stbv;

    p_one_strobe_r8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(stbv));

    p_din_stable_r8: assert property (@(posedge clk) disable iff (rst)
        (any_stb && $past(any_stb)) |-> $stable(phy_din));

    p_low_after_fall_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(any_stb) |=> !any_stb);

    p_low_before_rise_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(any_stb) |-> ($past(stbv, 2) == 4'b0000));

    p_drop_on_ack_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(any_stb) |-> (phy_ack || done));

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_busy_ends_done_r9: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    p_quiet_idle_r9: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !any_stb);

    p_err_sticky_r11: assert property (@(posedge clk) disable iff (rst)
        err |=> err);
endmodule

bind phycr_seq phycr_seq_chk #(.DW(DW)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .busy         (busy),
    .done         (done),
    .err          (err),
    .phy_din      (phy_din),
    .phy_cap_addr (phy_cap_addr),
    .phy_cap_data (phy_cap_data),
    .phy_rd       (phy_rd),
    .phy_wr       (phy_wr),
    .phy_ack      (phy_ack)
);

// File: tb/phycr_seq_test.sv
`timescale 1ns/1ps
module phycr_seq_test;
    localparam int DW = 16;
    localparam int TW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [DW-1:0] req_addr  = '0;
    logic [DW-1:0] req_wdata = '0;
    logic [TW-1:0] tmo_limit = 8'd200;
    logic          busy, done, err;
    logic [DW-1:0] rd_data, phy_din;
    logic          phy_cap_addr, phy_cap_data, phy_rd, phy_wr;
    logic [DW-1:0] phy_dout;
    logic          phy_ack;

    always #2.5 clk = ~clk;

    phycr_seq uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .tmo_limit(tmo_limit),
        .busy(busy), .done(done), .err(err), .rd_data(rd_data),
        .phy_din(phy_din), .phy_cap_addr(phy_cap_addr), .phy_cap_data(phy_cap_data),
        .phy_rd(phy_rd), .phy_wr(phy_wr), .phy_dout(phy_dout), .phy_ack(phy_ack)
    );

    // PHY model
    logic          dead  = 1'b0;
    logic          stuck = 1'b0;
    logic          fixd  = 1'b0;
    logic [DW-1:0] m_addr, m_data;
    logic [DW-1:0] mem [0:255];
    logic [3:0]    prev;
    logic [15:0]   seq;
    int            hs_count;
    int            dly, dcnt;
    logic [3:0]    stbv;
    assign stbv = {phy_cap_addr, phy_cap_data, phy_rd, phy_wr};

    always @(posedge clk) begin
        if (rst) begin
            phy_ack  <= 1'b0;
            phy_dout <= '0;
            prev     <= '0;
            seq      <= '0;
            hs_count <= 0;
            dly      <= 0;
            dcnt     <= 0;
            m_addr   <= '0;
            m_data   <= '0;
        end else begin
            prev <= stbv;
            if (phy_cap_addr && !prev[3]) begin
                m_addr <= phy_din; seq <= {seq[11:0], 4'h1}; hs_count <= hs_count + 1;
            end else if (phy_cap_data && !prev[2]) begin
                m_data <= phy_din; seq <= {seq[11:0], 4'h2}; hs_count <= hs_count + 1;
            end else if (phy_rd && !prev[1]) begin
                seq <= {seq[11:0], 4'h4}; hs_count <= hs_count + 1;
            end else if (phy_wr && !prev[0]) begin
                mem[m_addr[7:0]] <= m_data; seq <= {seq[11:0], 4'h3}; hs_count <= hs_count + 1;
            end
            phy_dout <= phy_rd ? mem[m_addr[7:0]] : (16'hBAD0 ^ {8'h00, m_addr[7:0]} ^ 16'h5A5A);
            if ((|stbv) != phy_ack) begin
                if (((|stbv) && !dead) || (!(|stbv) && !stuck)) begin
                    if (fixd || dcnt >= dly) begin
                        phy_ack <= |stbv;
                        dcnt    <= 0;
                        dly     <= int'($urandom_range(0, 4));
                    end else begin
                        dcnt <= dcnt + 1;
                    end
                end
            end else begin
                dcnt <= 0;
            end
        end
    end

    int errors = 0;
    int checks = 0;
    int cycle  = 0;
    logic [DW-1:0] golden [0:255];
    logic [DW-1:0] wlist [0:63];
    int nw = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cycle++;
        if (cycle > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected<150000 cycles", cycle);
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic run_op(input bit wr, input logic [DW-1:0] a, input logic [DW-1:0] d,
                          input bit hold, output int cyc, output int nhs);
        int  c0;
        bit  bbad;
        c0   = hs_count;
        bbad = 0;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(posedge clk);
        @(negedge clk);
        chk(busy === 1'b1, "R9 busy after accept", {31'd0, busy}, 1);
        if (hold) begin
            req_addr = ~a; req_wdata = ~d; req_write = ~wr;
        end else begin
            req_valid = 1'b0;
        end
        cyc = 0;
        while (done !== 1'b1 && cyc < 2000) begin
            @(posedge clk);
            cyc++;
            @(negedge clk);
            if (done !== 1'b1 && busy !== 1'b1) bbad = 1;
        end
        req_valid = 1'b0;
        chk(done === 1'b1, "R9 done seen", {31'd0, done}, 1);
        chk(!bbad && busy === 1'b0, "R9 busy held until done", {31'd0, busy}, 0);
        nhs = hs_count - c0;
    endtask

    task automatic do_write(input logic [DW-1:0] a, input logic [DW-1:0] d, input bit hold);
        int cyc, nhs;
        run_op(1'b1, a, d, hold, cyc, nhs);
        chk(nhs == 3 && seq[11:0] == 12'h123, "R5 write handshake order", {16'd0, seq}, 32'h123);
        chk(m_addr == a, "R3 address captured", {16'd0, m_addr}, {16'd0, a});
        chk(m_data == d, "R5 data captured", {16'd0, m_data}, {16'd0, d});
        chk(phy_ack === 1'b0, "R4 ack low at done", {31'd0, phy_ack}, 0);
        if (hold) chk(nhs == 3, "R2 request while busy ignored", nhs, 3);
        golden[a[7:0]] = d;
        if (nw < 64) begin wlist[nw] = a; nw++; end
    endtask

    task automatic do_read(input logic [DW-1:0] a, input bit hold);
        int cyc, nhs;
        run_op(1'b0, a, '0, hold, cyc, nhs);
        chk(nhs == 2 && seq[7:0] == 8'h14, "R6 read handshake order", {16'd0, seq}, 32'h14);
        chk(m_addr == a, "R3 address captured", {16'd0, m_addr}, {16'd0, a});
        chk(rd_data == golden[a[7:0]], "R6 read data", {16'd0, rd_data}, {16'd0, golden[a[7:0]]});
        chk(phy_ack === 1'b0, "R4 ack low at done", {31'd0, phy_ack}, 0);
        if (hold) chk(nhs == 2, "R2 request while busy ignored", nhs, 2);
    endtask

    initial begin
        int cyc, nhs;
        void'($urandom(32'd20240517));
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(stbv == 4'b0000, "R1 strobes low after reset", {28'd0, stbv}, 0);
        chk(phy_din == '0, "R1 din cleared", {16'd0, phy_din}, 0);
        chk(!busy && !done && !err, "R1 status cleared", {29'd0, busy, done, err}, 0);

        // Directed corner cases
        do_write(16'h0000, 16'hFFFF, 1'b0);
        do_write(16'hFFFF, 16'h0000, 1'b0);
        do_read(16'h0000, 1'b0);
        do_read(16'hFFFF, 1'b0);
        do_write(16'h1234, 16'hA5C3, 1'b1);
        do_read(16'h1234, 1'b1);
        chk(err === 1'b0, "R11 no error yet", {31'd0, err}, 0);

        // Random mix
        for (int i = 0; i < 48; i++) begin
            bit h;
            h = ($urandom_range(0, 5) == 0);
            if (nw < 4 || $urandom_range(0, 1) == 1) begin
                do_write(16'($urandom()), 16'($urandom()), h);
            end else begin
                do_read(wlist[$urandom_range(0, nw - 1)], h);
            end
        end

        // Timeout, acknowledge never rises
        tmo_limit = 8'd7;
        dead = 1'b1;
        run_op(1'b1, 16'h0042, 16'h7777, 1'b0, cyc, nhs);
        chk(cyc == 9, "R10 timeout latency no ack", cyc, 9);
        chk(err === 1'b1, "R10 err set on timeout", {31'd0, err}, 1);
        @(negedge clk);
        chk(stbv == 4'b0000 && !done, "R10 strobes dropped", {27'd0, done, stbv}, 0);
        dead = 1'b0;
        repeat (4) @(negedge clk);

        // Timeout, acknowledge stuck high
        tmo_limit = 8'd7;
        fixd  = 1'b1;
        stuck = 1'b1;
        run_op(1'b0, 16'h0099, '0, 1'b0, cyc, nhs);
        chk(cyc == 13, "R10 timeout latency ack stuck", cyc, 13);
        chk(stbv == 4'b0000 && err === 1'b1, "R10 stuck timeout state", {27'd0, err, stbv}, 32'h10);
        stuck = 1'b0;
        repeat (10) @(negedge clk);
        fixd = 1'b0;
        tmo_limit = 8'd200;

        // Error is sticky and operations still work
        do_write(16'h0A0A, 16'h5151, 1'b0);
        do_read(16'h0A0A, 1'b0);
        chk(err === 1'b1, "R11 err sticky", {31'd0, err}, 1);

        // Reset clears sticky error and bus
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(err === 1'b0 && phy_din == '0, "R1 reset clears err and din", {15'd0, err, phy_din}, 0);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule